// File: doc/BRIEF.md
# Modem Control Pin Router

This block holds a serial port's 8-bit modem control byte and drives the routing that follows from it. The host writes the byte through a simple write strobe and can read it back. The block drives the two active-low request outputs (request-to-send and data-terminal-ready) and reads the two active-low status inputs (clear-to-send and data-set-ready). When automatic hardware flow control is enabled by an external feature bit, one select bit places the automatic handshake on either the RTS/CTS pair or the DTR/DSR pair.

The block also decides where the serial data goes. It can route data straight between the pins and the shift engines, loop transmit data back to the receiver inside the block, or send data through an infrared path. In the infrared path the transmit output idles low and the receive input can be inverted. It keeps a software flow-control pause flag, which the "resume on any character" option can release. It also produces a clock enable for the baud generator that is either always on or active one cycle in four.

Top module: `modem_ctl_router`

## Requirements
- R1: After reset with `irStrap` low, `ctlRead` is 0x00, `rtsN` and `dtrN` are 1, and `txPin` follows `txData`.
- R2: A write stores `wrData` into the control byte, which appears on `ctlRead` one cycle later. Bit 3 is reserved and always reads 0.
- R3: With automatic control off for a pin, control bit 1 = 1 drives `rtsN` to 0 and control bit 0 = 1 drives `dtrN` to 0. When the bit is 0, the pin is 1.
- R4: With `autoHsEn` = 1 and control bit 2 = 0, `rtsN` equals `rxStop`, `ctsN` = 1 raises `txPause`, `dsrN` has no effect on `txPause`, and `dtrN` follows control bit 0.
- R5: With `autoHsEn` = 1 and control bit 2 = 1, `dtrN` equals `rxStop`, `dsrN` = 1 raises `txPause`, `ctsN` has no effect on `txPause`, and `rtsN` follows control bit 1.
- R6: With `autoHsEn` = 0, control bit 2 has no effect: both request pins follow their manual bits, and neither status input affects `txPause`.
- R7: Control bit 4 = 1 selects loopback. `rxData` follows `txData`, `rxPin` is ignored, `txPin`, `rtsN` and `dtrN` hold 1, `irTxPin` holds 0, and the internal request levels stand in for `ctsN`/`dsrN`, so that the level RTS would carry acts as CTS.
- R8: An `xoffRx` pulse sets `txPause` one cycle later. An `xonRx` pulse clears it. An `rxChar` pulse clears it only when control bit 5 = 1.
- R9: When `xoffRx` arrives in the same cycle as `xonRx` or `rxChar`, the pause is set.
- R10: Control bit 6 = 1 selects the infrared path. `txPin` holds 1, `irTxPin` = NOT `txData` (idle low), and `rxData` = `irRxPin` XOR `rxInvert`. Outside infrared mode, `rxInvert` has no effect.
- R11: With control bit 7 = 0, `clkEn` is 1 every cycle. With bit 7 = 1, `clkEn` is high for exactly one cycle in every four consecutive cycles.
- R12: Control bit 6 resets to the value of `irStrap` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irStrap | input | 1 | Reset value of the infrared enable bit |
| wrEn | input | 1 | Control byte write strobe |
| wrData | input | 8 | Control byte write data |
| ctlRead | output | 8 | Control byte readback |
| autoHsEn | input | 1 | Automatic hardware flow control enable |
| rxStop | input | 1 | Receiver asks the far end to stop sending |
| xoffRx | input | 1 | Pulse: pause character received |
| xonRx | input | 1 | Pulse: resume character received |
| rxChar | input | 1 | Pulse: any character received |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| dtrN | output | 1 | Data-terminal-ready pin, active low |
| txData | input | 1 | Serial data from the transmit engine |
| txPin | output | 1 | Serial transmit pin |
| irTxPin | output | 1 | Infrared transmit path output |
| rxPin | input | 1 | Serial receive pin |
| irRxPin | input | 1 | Infrared receive path input |
| rxInvert | input | 1 | Invert infrared receive input |
| rxData | output | 1 | Serial data to the receive engine |
| txPause | output | 1 | Transmitter must stall |
| clkEn | output | 1 | Baud generator clock enable |

## Verification
Pin routing, the request levels and the hardware part of `txPause` are combinational from the inputs and the stored byte. The bench therefore checks them in the same cycle, a short delay after it drives the inputs on a falling edge. A control write and a flow-control strobe take effect one rising edge later, so the bench drives them on one falling edge, releases them on the next, and samples there. The prescaler is checked over sixteen consecutive falling-edge samples: it must give exactly four pulses and no two pulses in adjacent cycles.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int BIT_DTR  = 0;
  localparam int BIT_RTS  = 1;
  localparam int BIT_PAIR = 2;
  localparam int BIT_RSVD = 3;
  localparam int BIT_LOOP = 4;
  localparam int BIT_XANY = 5;
  localparam int BIT_IR   = 6;
  localparam int BIT_DIV  = 7;

  typedef struct packed {
    logic div4;
    logic irMode;
    logic xonAny;
    logic loopEn;
    logic pairSel;
    logic rtsBit;
    logic dtrBit;
    logic swPaused;
  } ctlStrobes_t;
endpackage

// File: rtl/mcr_ctrl.sv
module mcr_ctrl
  import mcr_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irStrap,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             xoffRx,
  input  logic             xonRx,
  input  logic             rxChar,
  output ctlStrobes_t      strobes,
  output logic [CTL_W-1:0] ctlRead
);
  localparam logic [CTL_W-1:0] WR_MASK = ~(CTL_W'(1) << BIT_RSVD);

  logic [CTL_W-1:0] ctlQ;
  logic             pausedQ;
  logic             resumeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= CTL_W'(irStrap) << BIT_IR;
    end else if (wrEn) begin
      ctlQ <= wrData & WR_MASK;
    end
  end

  assign resumeHit = xonRx | (ctlQ[BIT_XANY] & rxChar);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pausedQ <= 1'b0;
    end else if (xoffRx) begin
      pausedQ <= 1'b1;
    end else if (resumeHit) begin
      pausedQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.div4     = ctlQ[BIT_DIV];
    strobes.irMode   = ctlQ[BIT_IR];
    strobes.xonAny   = ctlQ[BIT_XANY];
    strobes.loopEn   = ctlQ[BIT_LOOP];
    strobes.pairSel  = ctlQ[BIT_PAIR];
    strobes.rtsBit   = ctlQ[BIT_RTS];
    strobes.dtrBit   = ctlQ[BIT_DTR];
    strobes.swPaused = pausedQ;
  end

  assign ctlRead = ctlQ;

  assert_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (ctlRead == ($past(wrData) & WR_MASK)));

  assert_xoff_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    xoffRx |=> strobes.swPaused);

  assert_xon_any_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!xoffRx && rxChar && ctlRead[BIT_XANY]) |=> !strobes.swPaused);

  assert_no_any_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!xoffRx && !xonRx && !ctlRead[BIT_XANY] && strobes.swPaused) |=> strobes.swPaused);
endmodule

// File: rtl/mcr_datapath.sv
module mcr_datapath
  import mcr_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        autoHsEn,
  input  logic        rxStop,
  input  logic        ctsN,
  input  logic        dsrN,
  output logic        rtsN,
  output logic        dtrN,
  input  logic        txData,
  output logic        txPin,
  output logic        irTxPin,
  input  logic        rxPin,
  input  logic        irRxPin,
  input  logic        rxInvert,
  output logic        rxData,
  output logic        txPause,
  output logic        clkEn
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic autoRts, autoDtr;
  logic rtsLvl, dtrLvl;
  logic ctsEff, dsrEff;
  logic hwPause;

  // Handshake pair steering
  assign autoRts = autoHsEn & ~strobes.pairSel;
  assign autoDtr = autoHsEn &  strobes.pairSel;
  assign rtsLvl  = autoRts ? rxStop : ~strobes.rtsBit;
  assign dtrLvl  = autoDtr ? rxStop : ~strobes.dtrBit;

  assign rtsN = strobes.loopEn ? 1'b1 : rtsLvl;
  assign dtrN = strobes.loopEn ? 1'b1 : dtrLvl;

  assign ctsEff = strobes.loopEn ? rtsLvl : ctsN;
  assign dsrEff = strobes.loopEn ? dtrLvl : dsrN;

  assign hwPause = (autoRts & ctsEff) | (autoDtr & dsrEff);
  assign txPause = hwPause | strobes.swPaused;

  // Serial data routing
  always_comb begin
    if (strobes.loopEn) begin
      txPin   = 1'b1;
      irTxPin = 1'b0;
      rxData  = txData;
    end else if (strobes.irMode) begin
      txPin   = 1'b1;
      irTxPin = ~txData;
      rxData  = irRxPin ^ rxInvert;
    end else begin
      txPin   = txData;
      irTxPin = 1'b0;
      rxData  = rxPin;
    end
  end

  // Baud clock prescaler
  generate
    if (PRESCALE > 1) begin : g_div
      logic [CNT_W-1:0] cntQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cntQ <= '0;
        end else if (cntQ == CNT_W'(PRESCALE - 1)) begin
          cntQ <= '0;
        end else begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
      assign clkEn = strobes.div4 ? (cntQ == CNT_W'(PRESCALE - 1)) : 1'b1;
    end else begin : g_nodiv
      assign clkEn = 1'b1;
    end
  endgenerate

  assert_loop_pins_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loopEn |-> (rtsN && dtrN && txPin && !irTxPin));

  assert_ir_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.irMode && !strobes.loopEn && txData) |-> (!irTxPin && txPin));

  assert_prescale_gap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.div4 && clkEn) |=> (!strobes.div4 || !clkEn));

  assert_full_rate_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.div4 |-> clkEn);

  assert_no_auto_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!autoHsEn && !strobes.swPaused) |-> !txPause);
endmodule

// File: rtl/modem_ctl_router.sv
module modem_ctl_router
  import mcr_pkg::*;
#(
  parameter int CTL_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irStrap,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  output logic [CTL_W-1:0] ctlRead,
  input  logic             autoHsEn,
  input  logic             rxStop,
  input  logic             xoffRx,
  input  logic             xonRx,
  input  logic             rxChar,
  input  logic             ctsN,
  input  logic             dsrN,
  output logic             rtsN,
  output logic             dtrN,
  input  logic             txData,
  output logic             txPin,
  output logic             irTxPin,
  input  logic             rxPin,
  input  logic             irRxPin,
  input  logic             rxInvert,
  output logic             rxData,
  output logic             txPause,
  output logic             clkEn
);
  ctlStrobes_t strobes;

  mcr_ctrl #(.CTL_W(CTL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .irStrap(irStrap),
    .wrEn(wrEn), .wrData(wrData),
    .xoffRx(xoffRx), .xonRx(xonRx), .rxChar(rxChar),
    .strobes(strobes), .ctlRead(ctlRead)
  );

  mcr_datapath #(.PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .autoHsEn(autoHsEn), .rxStop(rxStop),
    .ctsN(ctsN), .dsrN(dsrN), .rtsN(rtsN), .dtrN(dtrN),
    .txData(txData), .txPin(txPin), .irTxPin(irTxPin),
    .rxPin(rxPin), .irRxPin(irRxPin), .rxInvert(rxInvert),
    .rxData(rxData), .txPause(txPause), .clkEn(clkEn)
  );
endmodule

// File: tb/tb_modem_ctl_router.sv
module tb_modem_ctl_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irStrap = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] ctlRead;
  logic autoHsEn = 1'b0, rxStop = 1'b0;
  logic xoffRx = 1'b0, xonRx = 1'b0, rxChar = 1'b0;
  logic ctsN = 1'b0, dsrN = 1'b0;
  logic rtsN, dtrN;
  logic txData = 1'b1;
  logic txPin, irTxPin;
  logic rxPin = 1'b1, irRxPin = 1'b0, rxInvert = 1'b0;
  logic rxData, txPause, clkEn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl_router dut (
    .clk(clk), .rstN(rstN), .irStrap(irStrap),
    .wrEn(wrEn), .wrData(wrData), .ctlRead(ctlRead),
    .autoHsEn(autoHsEn), .rxStop(rxStop),
    .xoffRx(xoffRx), .xonRx(xonRx), .rxChar(rxChar),
    .ctsN(ctsN), .dsrN(dsrN), .rtsN(rtsN), .dtrN(dtrN),
    .txData(txData), .txPin(txPin), .irTxPin(irTxPin),
    .rxPin(rxPin), .irRxPin(irRxPin), .rxInvert(rxInvert),
    .rxData(rxData), .txPause(txPause), .clkEn(clkEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeCtl(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic doXoff, input logic doXon, input logic doChar);
    @(negedge clk);
    xoffRx = doXoff; xonRx = doXon; rxChar = doChar;
    @(negedge clk);
    xoffRx = 1'b0; xonRx = 1'b0; rxChar = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    irStrap = 1'b1; rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 strap sets IR bit", ctlRead, 8'h40);
    check("R1 rtsN idle", {7'b0, rtsN}, 8'h01);
    check("R10 IR idle low", {7'b0, irTxPin}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    irStrap = 1'b0; rstN = 1'b0;
    @(negedge clk);
    txData = 1'b0; #1;
    check("R1 reset byte", ctlRead, 8'h00);
    check("R1 pins high", {6'b0, rtsN, dtrN}, 8'h03);
    check("R1 txPin follows", {7'b0, txPin}, 8'h00);
    txData = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_write;
    writeCtl(8'hFF);
    check("R2 bit3 reads zero", ctlRead, 8'hF7);
    writeCtl(8'h00);
    check("R2 clear", ctlRead, 8'h00);
  endtask

  task automatic t_manual;
    writeCtl(8'h02);
    check("R3 rts bit", {6'b0, rtsN, dtrN}, 8'h01);
    writeCtl(8'h01);
    check("R3 dtr bit", {6'b0, rtsN, dtrN}, 8'h02);
  endtask

  task automatic t_autoRts;
    autoHsEn = 1'b1; writeCtl(8'h00);
    rxStop = 1'b0; #1;
    check("R4 rts asserted", {6'b0, rtsN, dtrN}, 8'h01);
    rxStop = 1'b1; #1;
    check("R4 rts follows rxStop", {7'b0, rtsN}, 8'h01);
    ctsN = 1'b1; #1;
    check("R4 cts pauses", {7'b0, txPause}, 8'h01);
    ctsN = 1'b0; dsrN = 1'b1; #1;
    check("R4 dsr ignored", {7'b0, txPause}, 8'h00);
    dsrN = 1'b0; rxStop = 1'b0;
  endtask

  task automatic t_autoDtr;
    autoHsEn = 1'b1; writeCtl(8'h06);
    rxStop = 1'b1; #1;
    check("R5 dtr follows rxStop, rts manual", {6'b0, rtsN, dtrN}, 8'h01);
    rxStop = 1'b0; #1;
    check("R5 dtr asserted", {7'b0, dtrN}, 8'h00);
    dsrN = 1'b1; #1;
    check("R5 dsr pauses", {7'b0, txPause}, 8'h01);
    dsrN = 1'b0; ctsN = 1'b1; #1;
    check("R5 cts ignored", {7'b0, txPause}, 8'h00);
    ctsN = 1'b0;
  endtask

  task automatic t_noAuto;
    autoHsEn = 1'b0; writeCtl(8'h04);
    rxStop = 1'b1; ctsN = 1'b1; dsrN = 1'b1; #1;
    check("R6 pins manual off", {6'b0, rtsN, dtrN}, 8'h03);
    check("R6 no hw pause", {7'b0, txPause}, 8'h00);
    writeCtl(8'h07);
    check("R6 pins manual on", {6'b0, rtsN, dtrN}, 8'h00);
    rxStop = 1'b0; ctsN = 1'b0; dsrN = 1'b0;
  endtask

  task automatic t_loop;
    autoHsEn = 1'b0; writeCtl(8'h13);
    check("R7 pins held", {5'b0, rtsN, dtrN, txPin}, 8'h07);
    txData = 1'b0; rxPin = 1'b1; #1;
    check("R7 rx from tx low", {6'b0, rxData, txPin}, 8'h01);
    txData = 1'b1; rxPin = 1'b0; #1;
    check("R7 rx from tx high", {7'b0, rxData}, 8'h01);
    autoHsEn = 1'b1; writeCtl(8'h10);
    rxStop = 1'b1; ctsN = 1'b0; #1;
    check("R7 internal cts pauses", {7'b0, txPause}, 8'h01);
    rxStop = 1'b0; ctsN = 1'b1; #1;
    check("R7 cts pin ignored", {7'b0, txPause}, 8'h00);
    ctsN = 1'b0; autoHsEn = 1'b0; rxPin = 1'b1;
  endtask

  task automatic t_xon;
    autoHsEn = 1'b0; writeCtl(8'h00);
    pulse(1'b1, 1'b0, 1'b0);
    check("R8 xoff pauses", {7'b0, txPause}, 8'h01);
    pulse(1'b0, 1'b0, 1'b1);
    check("R8 char ignored without xon-any", {7'b0, txPause}, 8'h01);
    pulse(1'b0, 1'b1, 1'b0);
    check("R8 xon resumes", {7'b0, txPause}, 8'h00);
    writeCtl(8'h20);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    check("R8 any char resumes", {7'b0, txPause}, 8'h00);
    pulse(1'b1, 1'b0, 1'b1);
    check("R9 xoff beats char", {7'b0, txPause}, 8'h01);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b1, 1'b0);
    check("R9 xoff beats xon", {7'b0, txPause}, 8'h01);
    pulse(1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_ir;
    writeCtl(8'h40);
    txData = 1'b1; #1;
    check("R10 idle", {6'b0, txPin, irTxPin}, 8'h02);
    txData = 1'b0; #1;
    check("R10 ir tx active", {6'b0, txPin, irTxPin}, 8'h03);
    txData = 1'b1; irRxPin = 1'b1; rxInvert = 1'b0; #1;
    check("R10 rx plain", {7'b0, rxData}, 8'h01);
    rxInvert = 1'b1; #1;
    check("R10 rx inverted", {7'b0, rxData}, 8'h00);
    writeCtl(8'h00);
    rxPin = 1'b1; #1;
    check("R10 invert ignored outside IR", {7'b0, rxData}, 8'h01);
    rxInvert = 1'b0;
  endtask

  task automatic t_prescale;
    int pulses;
    logic prev;
    writeCtl(8'h00);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (clkEn) pulses++;
    end
    check("R11 full rate", 8'(pulses), 8'd8);
    writeCtl(8'h80);
    pulses = 0; prev = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (clkEn) begin
        pulses++;
        if (prev) check("R11 adjacent pulses", 8'h01, 8'h00);
      end
      prev = clkEn;
    end
    check("R11 quarter rate", 8'(pulses), 8'd4);
    writeCtl(8'h00);
  endtask

  initial begin
    t_reset();
    t_write();
    t_manual();
    t_autoRts();
    t_autoDtr();
    t_noAuto();
    t_loop();
    t_xon();
    t_ir();
    t_prescale();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule